// File: doc/BRIEF.md
# LPC Error Interrupt Flag Register

This block is an 8-bit status register on the local side of a host interface that connects to an LPC bus. It watches four host-side pins: the bus reset line, the power-down line, the frame line and the gate-A20 line. Each pin passes through a synchronizer. Falling edges on the first three set sticky error flags: bus reset, power-down and aborted transfer. A frame edge counts only while a transfer cycle is in progress. The gate-A20 level is readable at any time. Any set flag drives a single error interrupt line toward the local processor.

The local processor reads the register with a read strobe and clears a flag by a two-step handshake. First it reads the register and sees the flag as 1, which arms that flag. It then writes 0 to that flag's bit. The bus-side protocol engine supplies three qualifier inputs: a bus reset event (hardware or software), a bus shutdown event (hardware or software), and a transfer-in-progress level. The two events clear selected flags directly. Pin monitoring runs whatever state the rest of the host interface is in.

Top module: `lpcerr_flags`

## Requirements
- R1: After reset, bits 6 to 4 of `rdData` read 0 and `errIrq` is low.
- R2: Bit 7 of `rdData` shows the level of `gateA20Pin`. A pin change appears after two rising clock edges and not after one.
- R3: A falling edge on `hostRstPinN` sets bit 6. The flag shows on the third rising edge after the pin falls and not on the second. Rising edges set nothing.
- R4: A falling edge on `framePinN` sets bit 4 only if `xferActive` is high. With `xferActive` low the edge sets nothing.
- R5: A falling edge on `pwrDownPinN` sets bit 5.
- R6: A read that returns 1 in bit 6, 5 or 4 arms that flag. A later write with 0 in that bit clears the flag. Writing 1 has no effect. Writing 0 to a flag that is not armed has no effect. Every write disarms all flags.
- R7: `lpcRstEvt` clears bits 5 and 4 and leaves bit 6 unchanged. `lpcShdnEvt` clears only bit 4.
- R8: If a flag is set and cleared in the same cycle, the set wins and the flag stays 1.
- R9: `errIrq` is high in exactly the cycles in which any of bits 6 to 4 is 1.
- R10: Bits 3 to 0 always read 0, and writing to them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostRstPinN | input | 1 | Bus reset pin, asynchronous, active low |
| pwrDownPinN | input | 1 | Bus power-down pin, asynchronous, active low |
| framePinN | input | 1 | Bus frame pin, asynchronous, active low |
| gateA20Pin | input | 1 | Gate-A20 pin, asynchronous level |
| xferActive | input | 1 | A bus transfer cycle is in progress (synchronous) |
| lpcRstEvt | input | 1 | Bus hardware or software reset event, one cycle per event |
| lpcShdnEvt | input | 1 | Bus hardware or software shutdown event, one cycle per event |
| rdStb | input | 1 | Local processor read strobe |
| wrStb | input | 1 | Local processor write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from register state |
| errIrq | output | 1 | Error interrupt request |

## Verification
A pin change reaches bit 7 after two rising edges. It reaches a flag and `errIrq` after three: two synchronizer stages, then the edge register that also loads the flag. The bench therefore drives all inputs on falling clock edges and checks a flag two edges after a pin change, expecting it unchanged, and again one edge later, expecting it set. Strobes and bus events are registered once, so their effects are checked at the next falling edge. The set-beats-clear case places an armed write exactly on the third edge after a pin fall. Expected flag values in the sweeps come from the bench's own model: set by mask and cleared by AND with the written bits.

// File: rtl/lpcerr_pkg.sv
package lpcerr_pkg;
  // Monitored pin indices
  localparam int PIN_HRST  = 0;
  localparam int PIN_PDWN  = 1;
  localparam int PIN_FRAME = 2;
  localparam int PIN_GA20  = 3;
  localparam int NPINS     = 4;
  localparam logic [NPINS-1:0] PIN_IDLE = 4'b0111;

  // Flag indices inside the flag vector
  localparam int FLG_ABT  = 0;
  localparam int FLG_PDWN = 1;
  localparam int FLG_HRST = 2;
  localparam int NFLAGS   = 3;

  // Register layout
  localparam int REG_W    = 8;
  localparam int FLAG_LSB = 4;
  localparam int GA20_BIT = 7;

  typedef struct packed {
    logic [NFLAGS-1:0] set;
    logic [NFLAGS-1:0] clr;
    logic              ga20Lvl;
  } flagCtl_t;
endpackage

// File: rtl/lpcerr_ctrl.sv
module lpcerr_ctrl
  import lpcerr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NPINS-1:0]  pinsRaw,
  input  logic              xferActive,
  input  logic              lpcRstEvt,
  input  logic              lpcShdnEvt,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [REG_W-1:0]  wrData,
  input  logic [NFLAGS-1:0] flagsQ,
  output flagCtl_t          ctl
);
  localparam int NEDGE = NPINS - 1;

  logic [NPINS-1:0]  pinSync;
  logic [NEDGE-1:0]  pinPrev;
  logic [NEDGE-1:0]  pinFall;
  logic [NFLAGS-1:0] armQ;
  logic [NFLAGS-1:0] wrClr;
  logic [NFLAGS-1:0] evtClr;
  logic [NFLAGS-1:0] wrBits;
  logic              unusedWrBits;

  for (genvar p = 0; p < NPINS; p++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {SYNC_STAGES{PIN_IDLE[p]}};
      else       chain <= {chain[SYNC_STAGES-2:0], pinsRaw[p]};
    end
    assign pinSync[p] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= PIN_IDLE[NEDGE-1:0];
    else       pinPrev <= pinSync[NEDGE-1:0];
  end

  assign pinFall = pinPrev & ~pinSync[NEDGE-1:0];

  // Arm on a read that returns 1; any write disarms everything.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      armQ <= '0;
    else if (wrStb) armQ <= '0;
    else if (rdStb) armQ <= armQ | flagsQ;
  end

  assign wrBits       = wrData[FLAG_LSB +: NFLAGS];
  assign unusedWrBits = ^{wrData[REG_W-1:FLAG_LSB+NFLAGS], wrData[FLAG_LSB-1:0]};
  assign wrClr        = {NFLAGS{wrStb}} & armQ & ~wrBits;

  always_comb begin
    evtClr           = '0;
    evtClr[FLG_PDWN] = lpcRstEvt;
    evtClr[FLG_ABT]  = lpcRstEvt | lpcShdnEvt;
  end

  always_comb begin
    ctl               = '0;
    ctl.set[FLG_HRST] = pinFall[PIN_HRST];
    ctl.set[FLG_PDWN] = pinFall[PIN_PDWN];
    ctl.set[FLG_ABT]  = pinFall[PIN_FRAME] & xferActive;
    ctl.clr           = wrClr | evtClr;
    ctl.ga20Lvl       = pinSync[PIN_GA20];
  end
endmodule

// File: rtl/lpcerr_dp.sv
module lpcerr_dp
  import lpcerr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flagCtl_t          ctl,
  output logic [NFLAGS-1:0] flagsQ,
  output logic [REG_W-1:0]  rdData,
  output logic              errIrq
);
  // Set has priority over clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= (flagsQ & ~ctl.clr) | ctl.set;
  end

  always_comb begin
    rdData                        = '0;
    rdData[GA20_BIT]              = ctl.ga20Lvl;
    rdData[FLAG_LSB +: NFLAGS]    = flagsQ;
  end

  assign errIrq = |flagsQ;
endmodule

// File: rtl/lpcerr_flags.sv
module lpcerr_flags
  import lpcerr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostRstPinN,
  input  logic       pwrDownPinN,
  input  logic       framePinN,
  input  logic       gateA20Pin,
  input  logic       xferActive,
  input  logic       lpcRstEvt,
  input  logic       lpcShdnEvt,
  input  logic       rdStb,
  input  logic       wrStb,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       errIrq
);
  flagCtl_t          ctl;
  logic [NFLAGS-1:0] flagsQ;
  logic [NPINS-1:0]  pinsRaw;

  always_comb begin
    pinsRaw            = '0;
    pinsRaw[PIN_HRST]  = hostRstPinN;
    pinsRaw[PIN_PDWN]  = pwrDownPinN;
    pinsRaw[PIN_FRAME] = framePinN;
    pinsRaw[PIN_GA20]  = gateA20Pin;
  end

  lpcerr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinsRaw(pinsRaw), .xferActive(xferActive),
    .lpcRstEvt(lpcRstEvt), .lpcShdnEvt(lpcShdnEvt), .rdStb(rdStb),
    .wrStb(wrStb), .wrData(wrData), .flagsQ(flagsQ), .ctl(ctl)
  );

  lpcerr_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .flagsQ(flagsQ),
    .rdData(rdData), .errIrq(errIrq)
  );
endmodule

// File: rtl/lpcerr_flags_chk.sv
module lpcerr_flags_chk
  import lpcerr_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input flagCtl_t   ctl,
  input logic       xferActive,
  input logic       lpcRstEvt,
  input logic       wrStb,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       errIrq
);
  a_r3_set_loads: assert property (@(posedge clk) disable iff (!rstN)
    ctl.set[FLG_HRST] |=> rdData[6]);

  a_r4_abort_needs_xfer: assert property (@(posedge clk) disable iff (!rstN)
    ctl.set[FLG_ABT] |-> xferActive);

  a_r6_write_one_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && wrData[6] && rdData[6]) |=> rdData[6]);

  a_r7_evt_clears_pd: assert property (@(posedge clk) disable iff (!rstN)
    (lpcRstEvt && !ctl.set[FLG_PDWN]) |=> !rdData[5]);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.set[FLG_PDWN] && ctl.clr[FLG_PDWN]) |=> rdData[5]);

  a_r9_irq_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errIrq) |-> $past(|ctl.set));
endmodule

bind lpcerr_flags lpcerr_flags_chk u_chk (
  .clk(clk), .rstN(rstN), .ctl(ctl), .xferActive(xferActive),
  .lpcRstEvt(lpcRstEvt), .wrStb(wrStb), .wrData(wrData),
  .rdData(rdData), .errIrq(errIrq)
);

// File: tb/test_lpcerr_flags.sv
`timescale 1ns/1ps
module test_lpcerr_flags;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostRstPinN = 1'b1, pwrDownPinN = 1'b1, framePinN = 1'b1, gateA20Pin = 1'b0;
  logic xferActive = 1'b0, lpcRstEvt = 1'b0, lpcShdnEvt = 1'b0;
  logic rdStb = 1'b0, wrStb = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic errIrq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [2:0] expF;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  lpcerr_flags i_lpcerr_flags (
    .clk(clk), .rstN(rstN), .hostRstPinN(hostRstPinN), .pwrDownPinN(pwrDownPinN),
    .framePinN(framePinN), .gateA20Pin(gateA20Pin), .xferActive(xferActive),
    .lpcRstEvt(lpcRstEvt), .lpcShdnEvt(lpcShdnEvt), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .rdData(rdData), .errIrq(errIrq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkFlags(input string tag);
    #0.5;
    chk(rdData[6:4] == expF, tag, rdData[6:4], expF);
    chk(errIrq == (|expF), "R9 irq", errIrq, |expF);
  endtask

  // mask bit2=host reset pin, bit1=power-down pin, bit0=frame pin
  task automatic pulse(input logic [2:0] m, input logic xa);
    xferActive  = xa;
    hostRstPinN = ~m[2];
    pwrDownPinN = ~m[1];
    framePinN   = ~m[0];
    negs(3);
    hostRstPinN = 1'b1; pwrDownPinN = 1'b1; framePinN = 1'b1;
    negs(3);
    xferActive = 1'b0;
  endtask

  task automatic readReg(output logic [7:0] v);
    rdStb = 1'b1;
    #0.5 v = rdData;
    @(negedge clk);
    rdStb = 1'b0;
  endtask

  task automatic writeReg(input logic [7:0] d);
    wrStb = 1'b1; wrData = d;
    @(negedge clk);
    wrStb = 1'b0; wrData = 8'h00;
  endtask

  task automatic clearAll();
    logic [7:0] t;
    readReg(t);
    writeReg(8'h00);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    negs(3);
    #0.5;
    chk(rdData[6:4] == 3'b000, "R1 flags reset", rdData[6:4], 0);
    chk(errIrq == 1'b0, "R1 irq reset", errIrq, 0);
    rstN = 1'b1;
    negs(2);
    expF = 3'b000;
    checkFlags("R1 after release");

    // R2 gate-A20 latency
    gateA20Pin = 1'b1;
    negs(1); #0.5 chk(rdData[7] == 1'b0, "R2 ga20 one edge", rdData[7], 0);
    negs(1); #0.5 chk(rdData[7] == 1'b1, "R2 ga20 two edges", rdData[7], 1);
    gateA20Pin = 1'b0;
    negs(2); #0.5 chk(rdData[7] == 1'b0, "R2 ga20 low", rdData[7], 0);

    // R3 latency of host reset flag
    hostRstPinN = 1'b0;
    negs(2); #0.5 chk(rdData[6] == 1'b0, "R3 not before third edge", rdData[6], 0);
    negs(1); #0.5 chk(rdData[6] == 1'b1, "R3 set on third edge", rdData[6], 1);
    hostRstPinN = 1'b1;
    negs(4);
    expF = 3'b100;
    checkFlags("R3 rise sets nothing more");
    clearAll();

    // R3 R4 R5 sweep of pin masks and transfer state
    for (int x = 0; x < 2; x++) begin
      for (int m = 0; m < 8; m++) begin
        pulse(m[2:0], x[0]);
        expF = m[2:0] & {2'b11, x[0]};
        checkFlags(x[0] ? "R3/R5/R4 sweep xfer" : "R4 no xfer sweep");
        clearAll();
        expF = 3'b000;
        checkFlags("R6 clear after sweep");
      end
    end

    // R6 R10 armed write sweep
    for (int f = 1; f < 8; f++) begin
      for (int d = 0; d < 8; d++) begin
        pulse(f[2:0], 1'b1);
        readReg(rv);
        chk(rv[6:4] == f[2:0], "R6 read value", rv[6:4], f);
        chk(rv[3:0] == 4'h0, "R10 reserved read", rv[3:0], 0);
        writeReg({1'b0, d[2:0], 4'hF});
        expF = f[2:0] & d[2:0];
        checkFlags("R6 armed write");
        chk(rdData[3:0] == 4'h0, "R10 reserved after write", rdData[3:0], 0);
        clearAll();
      end
    end

    // R6 unarmed and disarmed writes
    pulse(3'b111, 1'b1);
    writeReg(8'h00);
    expF = 3'b111;
    checkFlags("R6 write0 without read");
    readReg(rv);
    writeReg(8'hFF);
    checkFlags("R6 write1 no effect");
    writeReg(8'h00);
    checkFlags("R6 disarmed by write");
    clearAll();

    // R7 bus events
    pulse(3'b111, 1'b1);
    lpcRstEvt = 1'b1; negs(1); lpcRstEvt = 1'b0;
    expF = 3'b100;
    checkFlags("R7 reset event");
    clearAll();
    pulse(3'b111, 1'b1);
    lpcShdnEvt = 1'b1; negs(1); lpcShdnEvt = 1'b0;
    expF = 3'b110;
    checkFlags("R7 shutdown event");
    clearAll();

    // R8 armed write collides with a new set
    pulse(3'b100, 1'b0);
    readReg(rv);
    hostRstPinN = 1'b0;
    negs(2);
    writeReg(8'h00);
    expF = 3'b100;
    checkFlags("R8 set beats write clear");
    hostRstPinN = 1'b1;
    negs(3);
    clearAll();
    // R8 bus reset event collides with power-down set
    pwrDownPinN = 1'b0;
    negs(2);
    lpcRstEvt = 1'b1; negs(1); lpcRstEvt = 1'b0;
    expF = 3'b010;
    checkFlags("R8 set beats event clear");
    pwrDownPinN = 1'b1;
    negs(3);
    clearAll();
    expF = 3'b000;
    checkFlags("R9 final idle");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule